// File: doc/BRIEF.md
# Staggered Multichannel PWM Generator

This block drives a bank of PWM outputs from one shared free-running period counter. Each channel holds a rise point and a fall point, both 12 bits wide. The output of a channel is high while the counter lies in the circular window from the rise point up to, but not including, the fall point.

An optional stagger setting moves both points of each channel forward by 256 counts per channel index. With stagger on, the outputs do not all switch on at the same count, and each channel keeps its duty cycle. With stagger off, channels that have equal settings switch together.

Settings arrive one byte at a time on a valid/ready write port and land in shadow registers. A commit copies the shadow values into a pending set. The commit comes either from a bus-stop strobe or from the fourth byte of a channel, as the mode register selects. The pending set becomes the live set only at the counter wrap, so no period mixes old and new rise or fall points.

Top module: `spwm_gen`

## Requirements
- R1: The period counter, visible on `period_cnt`, counts up by one each clock from 0 to 4095 and then returns to 0.
- R2: A channel output is high when the counter is at or past the effective rise point and below the effective fall point. It is low for the whole period when the two effective points are equal.
- R3: When the effective rise point is above the effective fall point, the high window wraps through the end of the period: the output is high at counts >= rise or < fall.
- R4: With stagger enabled, channel k's effective rise and fall points are the stored values plus k*256, taken modulo 4096.
- R5: With stagger disabled, channels with identical settings produce identical outputs in every cycle.
- R6: Byte address 4*k+i selects channel k. The value of i selects the field: 0 is rise bits 7:0, 1 is rise bits 11:8 (taken from data bits 3:0), 2 is fall bits 7:0 and 3 is fall bits 11:8 (taken from data bits 3:0). Data bits 7:4 of the high-byte writes are discarded. Address 64 is the mode register: bit 0 enables stagger and bit 1 selects per-channel commit.
- R7: In stop mode (mode bit 1 = 0), writes have no effect on the outputs until a `bus_stop` pulse commits all channels. A `bus_stop` in the same cycle as an accepted write commits that write as well.
- R8: In per-channel mode (mode bit 1 = 1), a channel commits on the accepted write that completes all four of its bytes since the mode register was last written or since its last commit. `bus_stop` has no effect in this mode.
- R9: Committed values and the stagger setting change the outputs only from the first cycle after the counter wraps. A commit made in the cycle where the counter shows 4095 is live at count 0.
- R10: A synchronous active-high reset clears the counter, all shadow, pending and live values and the mode bits, and drives every output low.
- R11: `wr_ready` is low during reset and high at all other times. A byte is accepted in any cycle where `wr_valid` and `wr_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Block can take a byte |
| wr_addr | input | 7 | Byte address |
| wr_data | input | 8 | Byte value |
| bus_stop | input | 1 | Bus stop strobe, commits all channels in stop mode |
| pwm_out | output | 16 | One PWM output per channel |
| period_cnt | output | 12 | Current period counter value |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a commit and the accepted write of a channel's last byte. The bench raises `bus_stop` together with a fourth byte and expects the new value of that byte to be live after the wrap. The second pair is a commit and the counter wrap. The bench places a `bus_stop` in the cycle where the counter shows 4095 and judges the whole following period against the new settings, starting at count 0. A commit made in mid-period is judged at a count where the old and new settings give different outputs.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic [1:0] {
    FLD_RISE_LO = 2'd0,
    FLD_RISE_HI = 2'd1,
    FLD_FALL_LO = 2'd2,
    FLD_FALL_HI = 2'd3
  } field_e;

  localparam int MODE_BIT_STAGGER = 0;
  localparam int MODE_BIT_PERCH   = 1;
  localparam int STAGGER_DIV      = 16;
endpackage

// File: rtl/spwm_counter.sv
module spwm_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stagger_in,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             stagger_live
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      stagger_live <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrap) stagger_live <= stagger_in;
    end
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX) |=> (cnt == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1)); // R1
  AST_STAGGER_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(stagger_live)); // R9
endmodule

// File: rtl/spwm_regfile.sv
module spwm_regfile
  import spwm_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic                         bus_stop,
  output logic                         stagger_en,
  output logic [NUM_CH-1:0][CNT_W-1:0] rise_d,
  output logic [NUM_CH-1:0][CNT_W-1:0] fall_d,
  output logic [NUM_CH-1:0]            commit
);
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int HI_W      = CNT_W - 8;
  localparam int MODE_ADDR = NUM_CH * 4;

  logic [NUM_CH-1:0][CNT_W-1:0] rise_q, fall_q;
  logic [NUM_CH-1:0][3:0]       seen_q, seen_d;
  logic                         perch_q;
  logic [CH_W-1:0]              ch_sel;
  field_e                       fld;
  logic                         is_ch, mode_wr;
  logic [3:0]                   seen_now;

  assign ch_sel  = wr_addr[2 +: CH_W];
  assign fld     = field_e'(wr_addr[1:0]);
  assign is_ch   = wr_en && (wr_addr < ADDR_W'(MODE_ADDR));
  assign mode_wr = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));

  always_comb begin
    rise_d   = rise_q;
    fall_d   = fall_q;
    seen_d   = seen_q;
    commit   = '0;
    seen_now = seen_q[ch_sel] | (4'b0001 << wr_addr[1:0]);
    if (is_ch) begin
      unique case (fld)
        FLD_RISE_LO: rise_d[ch_sel][7:0]       = wr_data;
        FLD_RISE_HI: rise_d[ch_sel][CNT_W-1:8] = wr_data[HI_W-1:0];
        FLD_FALL_LO: fall_d[ch_sel][7:0]       = wr_data;
        FLD_FALL_HI: fall_d[ch_sel][CNT_W-1:8] = wr_data[HI_W-1:0];
      endcase
      if (perch_q) begin
        if (seen_now == 4'hF) begin
          commit[ch_sel] = 1'b1;
          seen_d[ch_sel] = '0;
        end else begin
          seen_d[ch_sel] = seen_now;
        end
      end
    end
    if (mode_wr) seen_d = '0;
    if (!perch_q && bus_stop) commit = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q     <= '0;
      fall_q     <= '0;
      seen_q     <= '0;
      perch_q    <= 1'b0;
      stagger_en <= 1'b0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      seen_q <= seen_d;
      if (mode_wr) begin
        stagger_en <= wr_data[MODE_BIT_STAGGER];
        perch_q    <= wr_data[MODE_BIT_PERCH];
      end
    end
  end

  AST_PERCH_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    perch_q |-> $onehot0(commit)); // R8
  AST_PERCH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (perch_q && !wr_en) |-> (commit == '0)); // R8
  AST_STOP_MODE_ONLY_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    (!perch_q && !bus_stop) |-> (commit == '0)); // R7
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel #(
  parameter int CNT_W  = 12,
  parameter int CH_IDX = 0,
  parameter int STEP   = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [CNT_W-1:0] rise_new,
  input  logic [CNT_W-1:0] fall_new,
  input  logic             wrap,
  input  logic             stagger,
  input  logic [CNT_W-1:0] cnt,
  output logic             out
);
  localparam int               OFS_I = (CH_IDX * STEP) % (1 << CNT_W);
  localparam logic [CNT_W-1:0] OFS   = OFS_I[CNT_W-1:0];

  logic [CNT_W-1:0] pend_rise, pend_fall, live_rise, live_fall;
  logic [CNT_W-1:0] pend_rise_d, pend_fall_d, eff_rise, eff_fall;

  assign pend_rise_d = commit ? rise_new : pend_rise;
  assign pend_fall_d = commit ? fall_new : pend_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rise <= '0;
      pend_fall <= '0;
      live_rise <= '0;
      live_fall <= '0;
    end else begin
      pend_rise <= pend_rise_d;
      pend_fall <= pend_fall_d;
      if (wrap) begin
        live_rise <= pend_rise_d;
        live_fall <= pend_fall_d;
      end
    end
  end

  assign eff_rise = live_rise + (stagger ? OFS : '0);
  assign eff_fall = live_fall + (stagger ? OFS : '0);

  always_comb begin
    if (eff_rise == eff_fall)     out = 1'b0;
    else if (eff_rise < eff_fall) out = (cnt >= eff_rise) && (cnt < eff_fall);
    else                          out = (cnt >= eff_rise) || (cnt < eff_fall);
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(pend_rise) && $stable(pend_fall))); // R7
  AST_LIVE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(live_rise) && $stable(live_fall))); // R9
endmodule

// File: rtl/spwm_gen.sv
module spwm_gen #(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 12,
  parameter int ADDR_W = $clog2(NUM_CH * 4) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              bus_stop,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [CNT_W-1:0]  period_cnt
);
  localparam int STEP = (1 << CNT_W) / spwm_pkg::STAGGER_DIV;

  logic                         wr_en, wrap, stagger_en, stagger_live;
  logic [NUM_CH-1:0][CNT_W-1:0] rise_d, fall_d;
  logic [NUM_CH-1:0]            commit;

  always_ff @(posedge clk) wr_ready <= !rst;
  assign wr_en = wr_valid && wr_ready;

  spwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .stagger_in(stagger_en),
    .cnt(period_cnt), .wrap(wrap), .stagger_live(stagger_live)
  );

  spwm_regfile #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_stop(bus_stop), .stagger_en(stagger_en),
    .rise_d(rise_d), .fall_d(fall_d), .commit(commit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    spwm_channel #(.CNT_W(CNT_W), .CH_IDX(g), .STEP(STEP)) u_ch (
      .clk(clk), .rst(rst), .commit(commit[g]),
      .rise_new(rise_d[g]), .fall_new(fall_d[g]),
      .wrap(wrap), .stagger(stagger_live), .cnt(period_cnt), .out(pwm_out[g])
    );
  end

  AST_RESET_OUTPUTS_LOW: assert property (@(posedge clk)
    rst |=> (pwm_out == '0)); // R10
  AST_NOT_READY_IN_RESET: assert property (@(posedge clk)
    rst |=> !wr_ready); // R11
endmodule

// File: tb/spwm_gen_bench.sv
module spwm_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [6:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        bus_stop = 1'b0;
  logic [15:0] pwm_out;
  logic [11:0] period_cnt;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  spwm_gen u_spwm_gen (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .bus_stop(bus_stop),
    .pwm_out(pwm_out), .period_cnt(period_cnt)
  );

  // fields: channel[28:25], stagger[24], rise[23:12], fall[11:0]
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {4'd0,  1'b0, 12'h000, 12'h800},  // R2 plain window
    {4'd3,  1'b0, 12'h100, 12'h100},  // R2 equal points, always low
    {4'd5,  1'b0, 12'hE00, 12'h200},  // R3 wrapped window
    {4'd2,  1'b1, 12'h000, 12'h400},  // R4 shifted by 0x200
    {4'd15, 1'b1, 12'h000, 12'h200},  // R4 shift pushes window across wrap
    {4'd7,  1'b0, 12'hAAA, 12'hCCC},  // R2
    {4'd1,  1'b1, 12'h0F0, 12'h010},  // R3 R4 wrapped and shifted
    {4'd9,  1'b0, 12'h7FF, 12'h800}   // R2 one-count pulse
  };

  function automatic bit model(int ch, bit stag, int rise, int fall, int c);
    int r = (rise + (stag ? ch * 256 : 0)) % 4096;
    int f = (fall + (stag ? ch * 256 : 0)) % 4096;
    if (r == f) return 1'b0;
    if (r < f)  return (c >= r) && (c < f);
    return (c >= r) || (c < f);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input bit stop);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 7'(a); wr_data = 8'(d); bus_stop = stop;
    @(negedge clk);
    wr_valid = 1'b0; bus_stop = 1'b0;
  endtask

  task automatic prog(input int ch, input int rise, input int fall, input bit stop_last);
    wr(ch*4 + 0, rise & 8'hFF, 1'b0);
    wr(ch*4 + 1, (rise >> 8) & 4'hF, 1'b0);
    wr(ch*4 + 2, fall & 8'hFF, 1'b0);
    wr(ch*4 + 3, (fall >> 8) & 4'hF, stop_last);
  endtask

  task automatic stop_pulse();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic wait_wrap();
    do @(negedge clk); while (period_cnt != 12'd0);
  endtask

  task automatic wait_cnt(input int v);
    while (period_cnt != 12'(v)) @(negedge clk);
  endtask

  // compares one channel against the model for n cycles, from the current negedge
  task automatic scan(input int ch, input bit stag, input int rise, input int fall,
                      input int n, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch] !== model(ch, stag, rise, fall, int'(period_cnt))) bad++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    int prev;
    repeat (4) @(negedge clk);
    chk(wr_ready == 1'b0, "R11", int'(wr_ready), 0);
    chk(pwm_out == 16'h0, "R10", int'(pwm_out), 0);
    chk(period_cnt == 12'h0, "R10", int'(period_cnt), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R11", int'(wr_ready), 1);

    // R1 counter step and wrap
    prev = int'(period_cnt);
    @(negedge clk);
    chk(int'(period_cnt) == prev + 1, "R1", int'(period_cnt), prev + 1);
    wait_cnt(4095);
    @(negedge clk);
    chk(period_cnt == 12'd0, "R1", int'(period_cnt), 0);

    // table: R2 R3 R4 in stop mode
    for (int v = 0; v < NV; v++) begin
      int ch   = int'(VEC[v][28:25]);
      bit stag = VEC[v][24];
      int rise = int'(VEC[v][23:12]);
      int fall = int'(VEC[v][11:0]);
      wr(64, {7'd0, stag}, 1'b0);
      prog(ch, rise, fall, 1'b0);
      stop_pulse();
      wait_wrap();
      scan(ch, stag, rise, fall, 4096, bad);
      chk(bad == 0, $sformatf("R2/R3/R4 vector %0d", v), bad, 0);
    end
    wr(64, 0, 1'b0);

    // R7 writes without a stop do nothing
    prog(4, 12'h000, 12'h800, 1'b0);
    wait_wrap();
    scan(4, 1'b0, 0, 0, 4096, bad);
    chk(bad == 0, "R7 uncommitted write ignored", bad, 0);
    stop_pulse();
    wait_wrap();
    scan(4, 1'b0, 12'h000, 12'h800, 4096, bad);
    chk(bad == 0, "R7 stop commits", bad, 0);

    // R9 mid-period commit waits for wrap
    wait_cnt(12'h200);
    prog(4, 12'h000, 12'h100, 1'b0);
    stop_pulse();
    wait_cnt(12'h400);
    chk(pwm_out[4] == 1'b1, "R9 old value kept", int'(pwm_out[4]), 1);
    wait_wrap();
    scan(4, 1'b0, 12'h000, 12'h100, 4096, bad);
    chk(bad == 0, "R9 new value after wrap", bad, 0);

    // R9 commit in the 4095 cycle is live at count 0
    prog(4, 12'h000, 12'hC00, 1'b0);
    wait_cnt(4094);
    stop_pulse();
    chk(period_cnt == 12'd0, "R9 wrap alignment", int'(period_cnt), 0);
    scan(4, 1'b0, 12'h000, 12'hC00, 4096, bad);
    chk(bad == 0, "R9 commit at wrap", bad, 0);

    // R5 sync, and R7 stop together with the last byte
    prog(10, 12'h123, 12'h923, 1'b0);
    prog(11, 12'h123, 12'h923, 1'b1);
    wait_wrap();
    bad = 0;
    for (int i = 0; i < 4096; i++) begin
      if (pwm_out[10] !== pwm_out[11]) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R5 channels synchronized", bad, 0);
    scan(11, 1'b0, 12'h123, 12'h923, 4096, bad);
    chk(bad == 0, "R7 stop with last byte", bad, 0);

    // R8 per-channel commit, R6 reserved high bits
    wr(64, 2, 1'b0);
    wr(6*4 + 0, 8'h00, 1'b0);
    wr(6*4 + 1, 8'hF0, 1'b0);
    wr(6*4 + 2, 8'h00, 1'b0);
    stop_pulse();
    wait_wrap();
    scan(6, 1'b0, 0, 0, 4096, bad);
    chk(bad == 0, "R8 three bytes and stop ignored", bad, 0);
    wr(6*4 + 3, 8'hF8, 1'b0);
    wait_wrap();
    scan(6, 1'b0, 12'h000, 12'h800, 4096, bad);
    chk(bad == 0, "R8/R6 fourth byte commits, reserved bits dropped", bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule